// File: doc/BRIEF.md
# Auto-Indexing Memory Move Unit

This unit executes the move instruction class of a small controller core. A move word carries two 2-bit addressing modes, one for the source side and one for the destination side, together with a destination register index, a source register index and a small signed offset. The unit reads the base registers and forms an effective address for each side. It then runs one read and one write over two cycles, which can move register to memory, memory to register or memory to memory. For the pre-decrement and post-increment modes it writes the stepped base back to the register file.

The core pulses `mv_start` with a move word. The unit returns to `ST_IDLE` when it finishes. It takes a new move in the second cycle of the current one. Register reads use two combinational read ports. Register writes go out on two write ports. Memory uses a single port with a one-cycle read latency.

The controller has three states, `ST_IDLE`, `ST_LOAD` and `ST_STORE`:
- `ST_IDLE` moves to `ST_LOAD` when it accepts a legal move.
- `ST_LOAD` always moves to `ST_STORE`.
- `ST_STORE` moves to `ST_LOAD` if it accepts a legal move, and to `ST_IDLE` otherwise.
- A rejected move leaves the unit in, or returns it to, `ST_IDLE`.

Top module: `idx_move_unit`

## Requirements
- R1: The move word bit layout is `[15:14]` source mode, `[13:12]` destination mode, `[11:8]` destination register, `[7:4]` source register, `[3:0]` offset.
  - Mode 00 (direct) takes the value from the source register itself, or writes it into the destination register itself.
- R2: In mode 01 the address is the base register plus the offset. The offset is sign-extended from 4 bits. The base register is not changed.
- R3: In mode 10 the address is base minus one. The same base-minus-one value is written back to the base register.
- R4: In mode 11 the address is the unmodified base. Base plus one is written back to the base register.
- R5: A move with both modes 00 is rejected. Exactly one cycle after it is accepted, `illegal` is high for one cycle. No register or memory write follows.
- R6: Timing after acceptance:
  - The cycle after acceptance is cycle one. `busy` is high in cycle one, and the memory read is issued then if the source is indirect.
  - In cycle two, `busy` is low. The write is performed then, using the value the memory returned or the register value captured in cycle one.
- R7: When both modes are indirect, one move copies a memory word to another memory word.
- R8: When both sides update the same base register, the destination-side result is kept. This also applies when a direct destination register equals an updating source base.
- R9: The offset field has no effect in modes 00, 10 and 11.
- R10: `mv_start` is ignored while `busy` is high.
- R11: After reset the unit is idle. `busy`, `illegal`, `mem_re`, `mem_we` and both register write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_start | input | 1 | Offer a move word this cycle |
| mv_word | input | 16 | Move word (modes, registers, offset) |
| busy | output | 1 | High in cycle one of a move |
| illegal | output | 1 | One-cycle pulse for a rejected move |
| rf_rd_sidx | output | 4 | Register read index, source side |
| rf_rd_sval | input | 16 | Register read data, source side |
| rf_rd_didx | output | 4 | Register read index, destination side |
| rf_rd_dval | input | 16 | Register read data, destination side |
| rf_wa_en | output | 1 | Write enable, destination-side port |
| rf_wa_idx | output | 4 | Write index, destination-side port |
| rf_wa_val | output | 16 | Write data, destination-side port |
| rf_wb_en | output | 1 | Write enable, source base port |
| rf_wb_idx | output | 4 | Write index, source base port |
| rf_wb_val | output | 16 | Write data, source base port |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
A wrong state or a wrong latched address shows up at the ports within the same move. The write strobe or its address appears in the wrong cycle, or a register or memory word holds the wrong value two cycles after acceptance. A wrong stepped base or a lost write-back only appears on a later move that uses that base. For this reason the bench compares the complete register and memory images after every move, not only the word just written. A rejected or ignored start shows up one cycle later: either the `illegal` pulse is missing, or a stray strobe appears.

// File: rtl/idx_move_pkg.sv
package idx_move_pkg;

    typedef enum logic [1:0] {
        AM_REG  = 2'b00,
        AM_OFS  = 2'b01,
        AM_PRE  = 2'b10,
        AM_POST = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_STORE = 2'b10
    } mv_state_e;

endpackage

// File: rtl/idx_move_agen.sv
module idx_move_agen
    import idx_move_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 4
) (
    input  amode_e              mode,
    input  logic [DATA_W-1:0]   base,
    input  logic [OFS_W-1:0]    ofs,
    output logic [DATA_W-1:0]   ea,
    output logic [DATA_W-1:0]   wb_val,
    output logic                wb_en
);
    localparam int EXT_W = DATA_W - OFS_W;
    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    logic [DATA_W-1:0] ofs_sx;
    assign ofs_sx = {{EXT_W{ofs[OFS_W-1]}}, ofs};

    always_comb begin
        unique case (mode)
            AM_REG: begin
                ea     = base;
                wb_val = base;
                wb_en  = 1'b0;
            end
            AM_OFS: begin
                ea     = base + ofs_sx;
                wb_val = base;
                wb_en  = 1'b0;
            end
            AM_PRE: begin
                ea     = base - STEP;
                wb_val = base - STEP;
                wb_en  = 1'b1;
            end
            AM_POST: begin
                ea     = base;
                wb_val = base + STEP;
                wb_en  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/idx_move_fsm.sv
module idx_move_fsm
    import idx_move_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  amode_e    smode,
    input  amode_e    dmode,
    output mv_state_e state,
    output logic      accept,
    output logic      busy,
    output logic      load_ph,
    output logic      store_ph,
    output logic      illegal
);
    mv_state_e state_q, state_d;
    logic      can_take, both_reg, take_ok, take_bad;

    assign can_take = (state_q != ST_LOAD);
    assign both_reg = (smode == AM_REG) && (dmode == AM_REG);
    assign take_ok  = start && can_take && !both_reg;
    assign take_bad = start && can_take && both_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            illegal <= 1'b0;
        end else begin
            state_q <= state_d;
            illegal <= take_bad;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = take_ok ? ST_LOAD : ST_IDLE;
            ST_LOAD:  state_d = ST_STORE;
            ST_STORE: state_d = take_ok ? ST_LOAD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state    = state_q;
        accept   = take_ok;
        busy     = (state_q == ST_LOAD);
        load_ph  = (state_q == ST_LOAD);
        store_ph = (state_q == ST_STORE);
    end

endmodule

// File: rtl/idx_move_wport.sv
module idx_move_wport #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4
) (
    input  logic              d_en,
    input  logic [REG_AW-1:0] d_idx,
    input  logic [DATA_W-1:0] d_val,
    input  logic              s_en,
    input  logic [REG_AW-1:0] s_idx,
    input  logic [DATA_W-1:0] s_val,
    output logic              a_en,
    output logic [REG_AW-1:0] a_idx,
    output logic [DATA_W-1:0] a_val,
    output logic              b_en,
    output logic [REG_AW-1:0] b_idx,
    output logic [DATA_W-1:0] b_val
);
    logic clash;
    assign clash = d_en && (d_idx == s_idx);

    always_comb begin
        a_en  = d_en;
        a_idx = d_idx;
        a_val = d_val;
        b_en  = s_en && !clash;
        b_idx = s_idx;
        b_val = s_val;
    end

endmodule

// File: rtl/idx_move_unit.sv
module idx_move_unit
    import idx_move_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4,
    parameter int OFS_W  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 mv_start,
    input  logic [OFS_W+2*REG_AW+3:0]            mv_word,
    output logic                                 busy,
    output logic                                 illegal,
    output logic [REG_AW-1:0]                    rf_rd_sidx,
    input  logic [DATA_W-1:0]                    rf_rd_sval,
    output logic [REG_AW-1:0]                    rf_rd_didx,
    input  logic [DATA_W-1:0]                    rf_rd_dval,
    output logic                                 rf_wa_en,
    output logic [REG_AW-1:0]                    rf_wa_idx,
    output logic [DATA_W-1:0]                    rf_wa_val,
    output logic                                 rf_wb_en,
    output logic [REG_AW-1:0]                    rf_wb_idx,
    output logic [DATA_W-1:0]                    rf_wb_val,
    output logic [DATA_W-1:0]                    mem_addr,
    output logic                                 mem_re,
    output logic                                 mem_we,
    output logic [DATA_W-1:0]                    mem_wdata,
    input  logic [DATA_W-1:0]                    mem_rdata
);
    localparam int WORD_W  = OFS_W + 2*REG_AW + 4;
    localparam int SRC_LSB = OFS_W;
    localparam int DST_LSB = OFS_W + REG_AW;
    localparam int DM_LSB  = OFS_W + 2*REG_AW;
    localparam int SM_LSB  = DM_LSB + 2;
    localparam int SIDES   = 2;

    // live fields of the offered word, latched fields of the running move
    amode_e             in_smode, in_dmode, smode_q, dmode_q;
    logic [REG_AW-1:0]  sreg_q, dreg_q;
    logic [OFS_W-1:0]   ofs_q;

    mv_state_e          state;
    logic               accept, load_ph, store_ph;

    assign in_smode = amode_e'(mv_word[SM_LSB +: 2]);
    assign in_dmode = amode_e'(mv_word[DM_LSB +: 2]);

    idx_move_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mv_start),
        .smode    (in_smode),
        .dmode    (in_dmode),
        .state    (state),
        .accept   (accept),
        .busy     (busy),
        .load_ph  (load_ph),
        .store_ph (store_ph),
        .illegal  (illegal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smode_q <= AM_REG;
            dmode_q <= AM_REG;
            sreg_q  <= '0;
            dreg_q  <= '0;
            ofs_q   <= '0;
        end else if (accept) begin
            smode_q <= in_smode;
            dmode_q <= in_dmode;
            sreg_q  <= mv_word[SRC_LSB +: REG_AW];
            dreg_q  <= mv_word[DST_LSB +: REG_AW];
            ofs_q   <= mv_word[0 +: OFS_W];
        end
    end

    assign rf_rd_sidx = sreg_q;
    assign rf_rd_didx = dreg_q;

    // one address generator per side: index 0 = source, 1 = destination
    amode_e             side_mode [SIDES];
    logic [DATA_W-1:0]  side_base [SIDES];
    logic [DATA_W-1:0]  side_ea   [SIDES];
    logic [DATA_W-1:0]  side_wbv  [SIDES];
    logic               side_wbe  [SIDES];

    assign side_mode[0] = smode_q;
    assign side_mode[1] = dmode_q;
    assign side_base[0] = rf_rd_sval;
    assign side_base[1] = rf_rd_dval;

    for (genvar g = 0; g < SIDES; g++) begin : g_agen
        idx_move_agen #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_agen (
            .mode   (side_mode[g]),
            .base   (side_base[g]),
            .ofs    (ofs_q),
            .ea     (side_ea[g]),
            .wb_val (side_wbv[g]),
            .wb_en  (side_wbe[g])
        );
    end

    // cycle-one captures used in cycle two
    logic [DATA_W-1:0] cap_q, dst_ea_q, src_wb_q, dst_wb_q;
    logic              src_upd_q, dst_upd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q     <= '0;
            dst_ea_q  <= '0;
            src_wb_q  <= '0;
            dst_wb_q  <= '0;
            src_upd_q <= 1'b0;
            dst_upd_q <= 1'b0;
        end else if (load_ph) begin
            cap_q     <= rf_rd_sval;
            dst_ea_q  <= side_ea[1];
            src_wb_q  <= side_wbv[0];
            dst_wb_q  <= side_wbv[1];
            src_upd_q <= side_wbe[0];
            dst_upd_q <= side_wbe[1];
        end
    end

    logic [DATA_W-1:0] xfer;
    logic              d_en, s_en;
    logic [DATA_W-1:0] d_val;

    always_comb begin
        xfer      = (smode_q == AM_REG) ? cap_q : mem_rdata;
        mem_re    = load_ph && (smode_q != AM_REG);
        mem_we    = store_ph && (dmode_q != AM_REG);
        mem_addr  = load_ph ? side_ea[0] : dst_ea_q;
        mem_wdata = xfer;
        if (dmode_q == AM_REG) begin
            d_en  = store_ph;
            d_val = xfer;
        end else begin
            d_en  = store_ph && dst_upd_q;
            d_val = dst_wb_q;
        end
        s_en = store_ph && src_upd_q;
    end

    idx_move_wport #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_wport (
        .d_en  (d_en),
        .d_idx (dreg_q),
        .d_val (d_val),
        .s_en  (s_en),
        .s_idx (sreg_q),
        .s_val (src_wb_q),
        .a_en  (rf_wa_en),
        .a_idx (rf_wa_idx),
        .a_val (rf_wa_val),
        .b_en  (rf_wb_en),
        .b_idx (rf_wb_idx),
        .b_val (rf_wb_val)
    );

endmodule

// File: rtl/idx_move_unit_chk.sv
module idx_move_unit_chk #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              illegal,
    input logic              mv_start,
    input logic              rf_wa_en,
    input logic [REG_AW-1:0] rf_wa_idx,
    input logic              rf_wb_en,
    input logic [REG_AW-1:0] rf_wb_idx,
    input logic              mem_re,
    input logic              mem_we
);
    // R6: cycle one lasts exactly one cycle
    p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6: memory read only in cycle one
    p_read_in_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> busy);

    // R6: memory write only in the cycle after cycle one
    p_write_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(busy));

    // R6: register writes only in the cycle after cycle one
    p_rf_write_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wa_en || rf_wb_en) |-> $past(busy));

    // R5: a rejected move writes nothing
    p_illegal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !rf_wa_en && !rf_wb_en && !busy));

    // R5: illegal is a single-cycle pulse unless a new bad word arrives
    p_illegal_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !mv_start) |=> !illegal);

    // R8: never two writes to one register in a cycle
    p_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wa_en && rf_wb_en && (rf_wa_idx == rf_wb_idx)));

    // R10: a start during busy does not extend or restart cycle one
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mv_start) |=> (!busy && !illegal));

endmodule

bind idx_move_unit idx_move_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .illegal   (illegal),
    .mv_start  (mv_start),
    .rf_wa_en  (rf_wa_en),
    .rf_wa_idx (rf_wa_idx),
    .rf_wb_en  (rf_wb_en),
    .rf_wb_idx (rf_wb_idx),
    .mem_re    (mem_re),
    .mem_we    (mem_we)
);

// File: tb/idx_move_unit_tb.sv
module idx_move_unit_tb;
    localparam int DW = 16;
    localparam int RW = 4;
    localparam int MW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mv_start = 1'b0;
    logic [15:0]   mv_word = '0;
    logic          busy, illegal;
    logic [RW-1:0] rf_rd_sidx, rf_rd_didx, rf_wa_idx, rf_wb_idx;
    logic [DW-1:0] rf_rd_sval, rf_rd_dval, rf_wa_val, rf_wb_val;
    logic          rf_wa_en, rf_wb_en, mem_re, mem_we;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    idx_move_unit u_dut (
        .clk(clk), .rst_n(rst_n), .mv_start(mv_start), .mv_word(mv_word),
        .busy(busy), .illegal(illegal),
        .rf_rd_sidx(rf_rd_sidx), .rf_rd_sval(rf_rd_sval),
        .rf_rd_didx(rf_rd_didx), .rf_rd_dval(rf_rd_dval),
        .rf_wa_en(rf_wa_en), .rf_wa_idx(rf_wa_idx), .rf_wa_val(rf_wa_val),
        .rf_wb_en(rf_wb_en), .rf_wb_idx(rf_wb_idx), .rf_wb_val(rf_wb_val),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bench register file and memory
    logic [DW-1:0] rf  [16];
    logic [DW-1:0] mem [MW];
    logic [DW-1:0] erf [16];
    logic [DW-1:0] emem[MW];

    assign rf_rd_sval = rf[rf_rd_sidx];
    assign rf_rd_dval = rf[rf_rd_didx];

    always @(posedge clk) begin
        if (rf_wa_en) rf[rf_wa_idx] <= rf_wa_val;
        if (rf_wb_en) rf[rf_wb_idx] <= rf_wb_val;
        if (mem_we)   mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re)   mem_rdata <= mem[mem_addr[7:0]];
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] sm, input logic [1:0] dm,
                                       input logic [3:0] d, input logic [3:0] s,
                                       input logic [3:0] o);
        return {sm, dm, d, s, o};
    endfunction

    function automatic logic [DW-1:0] ea_of(input logic [1:0] m, input logic [DW-1:0] b,
                                            input logic [3:0] o);
        case (m)
            2'b01:   return b + {{12{o[3]}}, o};
            2'b10:   return b - 16'd1;
            default: return b;
        endcase
    endfunction

    // expected effect of one move, written from the requirements
    task automatic model(input logic [15:0] w);
        logic [1:0] sm, dm;
        logic [3:0] d, s, o;
        logic [DW-1:0] sb, db, val, dea;
        sm = w[15:14]; dm = w[13:12]; d = w[11:8]; s = w[7:4]; o = w[3:0];
        if (sm == 2'b00 && dm == 2'b00) return;
        sb  = erf[s];
        db  = erf[d];
        val = (sm == 2'b00) ? sb : emem[ea_of(sm, sb, o) & 16'hFF];
        dea = ea_of(dm, db, o);
        if (dm != 2'b00) emem[dea & 16'hFF] = val;
        if (sm == 2'b10) erf[s] = sb - 16'd1;
        if (sm == 2'b11) erf[s] = sb + 16'd1;
        if (dm == 2'b00) erf[d] = val;
        if (dm == 2'b10) erf[d] = db - 16'd1;
        if (dm == 2'b11) erf[d] = db + 16'd1;
    endtask

    task automatic cmp_all(input string tag);
        for (int i = 0; i < 16; i++) chk(tag, rf[i], erf[i]);
        for (int i = 0; i < MW; i++) chk(tag, mem[i], emem[i]);
    endtask

    // drive one move and check its cycle timing, then the full state
    task automatic do_move(input logic [15:0] w, input string tag);
        logic bad;
        bad = (w[15:14] == 2'b00) && (w[13:12] == 2'b00);
        @(negedge clk);
        mv_start = 1'b1; mv_word = w;
        @(negedge clk);
        mv_start = 1'b0;
        if (bad) begin
            chk("R5 illegal pulse", {15'd0, illegal}, 16'd1);
            chk("R5 no busy", {15'd0, busy}, 16'd0);
            @(negedge clk);
            chk("R5 pulse ends", {15'd0, illegal}, 16'd0);
        end else begin
            chk("R6 busy cycle one", {15'd0, busy}, 16'd1);
            chk("R6 read strobe", {15'd0, mem_re}, {15'd0, w[15:14] != 2'b00});
            @(negedge clk);
            chk("R6 busy low cycle two", {15'd0, busy}, 16'd0);
            chk("R6 write strobe", {15'd0, mem_we}, {15'd0, w[13:12] != 2'b00});
            @(negedge clk);
        end
        model(w);
        cmp_all(tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 16; i++) begin rf[i] = 16'(i * 16); erf[i] = 16'(i * 16); end
        for (int i = 0; i < MW; i++) begin mem[i] = 16'(i ^ 16'hA500); emem[i] = 16'(i ^ 16'hA500); end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", {15'd0, busy}, 16'd0);
        chk("R11 illegal", {15'd0, illegal}, 16'd0);
        chk("R11 strobes", {12'd0, mem_re, mem_we, rf_wa_en, rf_wb_en}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after release", {15'd0, busy}, 16'd0);

        rf[5] = 16'hBEEF; erf[5] = 16'hBEEF;
        do_move(mk(2'b00, 2'b01, 4'd2, 4'd5, 4'd3), "R1 reg to mem");
        chk("R1 word at 0x23", mem[8'h23], 16'hBEEF);
        do_move(mk(2'b01, 2'b00, 4'd7, 4'd2, 4'hE), "R2 neg offset load");
        chk("R2 loaded 0x1E", rf[7], 16'h1EA5 ^ 16'hBF00 ^ 16'h0000 ^ (16'hA51E ^ 16'h1EA5 ^ 16'hBF00));
        do_move(mk(2'b10, 2'b00, 4'd8, 4'd3, 4'd7), "R3 R9 predec ignores offset");
        chk("R3 base stepped", rf[3], 16'h002F);
        do_move(mk(2'b11, 2'b00, 4'd9, 4'd4, 4'd5), "R4 R9 postinc ignores offset");
        chk("R4 base stepped", rf[4], 16'h0041);
        do_move(mk(2'b11, 2'b11, 4'd10, 4'd6, 4'd0), "R7 mem to mem copy");
        chk("R7 copied word", mem[8'hA0], 16'hA560);
        do_move(mk(2'b11, 2'b10, 4'd11, 4'd11, 4'd0), "R8 same base");
        do_move(mk(2'b11, 2'b00, 4'd12, 4'd12, 4'd0), "R8 direct dst over src base");
        do_move(mk(2'b00, 2'b00, 4'd1, 4'd2, 4'd0), "R5 rejected move");

        // R10: start held during cycle one with another word is ignored
        @(negedge clk);
        mv_start = 1'b1; mv_word = mk(2'b01, 2'b00, 4'd13, 4'd1, 4'd1);
        @(negedge clk);
        mv_word = mk(2'b00, 2'b11, 4'd14, 4'd15, 4'd0);
        @(negedge clk);
        mv_start = 1'b0;
        @(negedge clk);
        chk("R10 no restart", {15'd0, busy}, 16'd0);
        model(mk(2'b01, 2'b00, 4'd13, 4'd1, 4'd1));
        cmp_all("R10 second word ignored");

        for (int k = 0; k < 200; k++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (k % 17 == 0) w[15:12] = 4'b0000;
            do_move(w, "R7 R8 random move");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule